// File: doc/BRIEF.md
# Maskable Interrupt Arbitration Sequencer

This block decides when a small 8-bit core gives up its normal instruction flow to service a maskable interrupt. It keeps a global interrupt enable, one enable bit per source and one pending flag per source. Event strobes set the pending flags, and software writes clear them. A source counts as active when its pending flag and its enable bit are both set. The core marks every instruction start with a boundary strobe. At that strobe the block checks whether the request can be accepted.

Once a request is accepted, the block runs a fixed seven-cycle acknowledge sequence. The global enable drops on the edge that accepts the request. In the first cycle of the sequence, the address of the instruction about to execute is handed to the stack. In the last cycle, the program counter is loaded with a single common vector. Separately, a priority pick reports the highest-priority active source as an index with a valid flag, so the common handler can dispatch to the right routine. The core issues one instruction cycle per clock.

Top module: `mirq_sequencer`

## Requirements
- R1: After reset the global enable, every per-source enable bit and every pending flag read 0, and no acknowledge sequence is in progress.
- R2: A one-cycle strobe on `evt_strobe[i]` sets `pending[i]` on the next clock. Only a software clear mask on `pend_clr` clears the flag. When a set and a clear of the same bit arrive in the same cycle, the flag ends up set. The acknowledge sequence never clears a pending flag.
- R3: When `en_wr` is high, the whole `enable` register takes `en_wdata` on the next clock. When `gie_wr` is high, `gie` takes `gie_wdata` on the next clock, except as stated in R7.
- R4: A request is accepted on a clock where all of the following hold: `insn_start` is high, `gie` is 1, at least one source has both its pending and enable bits set, `nmi_busy` is low, `skip_pending` is low, and no sequence is running. `ack_busy` rises on the next clock.
- R5: A flag that was already pending before its enable bit and `gie` were set triggers acceptance at the first instruction boundary after both are set.
- R6: A boundary with `skip_pending` high accepts nothing. The request is accepted at the following boundary if the conditions of R4 still hold there.
- R7: `gie` reads 0 from the clock after acceptance. This holds even if a software write to set `gie` arrives in the accepting cycle.
- R8: In the first cycle of the sequence, `push_valid` is high for exactly one cycle. In that cycle `push_data` equals the `ret_addr` presented in the accepting cycle.
- R9: `ack_busy` stays high for exactly 7 cycles. In the seventh of those cycles `pc_load` is high for one cycle with `pc_value` = 0x0FF. Instruction boundaries that arrive while the sequence runs are ignored.
- R10: `vis_valid` is 1 exactly when some source has both its pending and enable bits set. `vis_idx` then gives the lowest such index, because index 0 has the highest priority.
- R11: If software sets `gie` again (for example inside a handler), a source that is still active is accepted at the next boundary after the sequence ends.
- R12: While `nmi_busy` is high, no request is accepted. The pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | NSRC | Per-source event pulses (already synchronous) |
| pend_clr | input | NSRC | Software clear mask for pending flags |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NSRC | Enable register write data |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Global enable write data |
| insn_start | input | 1 | Marks the start of an instruction |
| skip_pending | input | 1 | The instruction at this boundary is to be skipped |
| nmi_busy | input | 1 | A non-maskable service routine is running |
| ret_addr | input | AW | Address of the instruction about to execute |
| gie | output | 1 | Global enable state |
| enable | output | NSRC | Per-source enable bits |
| pending | output | NSRC | Per-source pending flags |
| vis_idx | output | IW | Index of the highest-priority active source |
| vis_valid | output | 1 | Some source is active |
| ack_busy | output | 1 | Acknowledge sequence in progress |
| push_valid | output | 1 | Push the return address this cycle |
| push_data | output | AW | Return address to push |
| pc_load | output | 1 | Load the program counter this cycle |
| pc_value | output | AW | Vector address for the PC load |

## Verification
The checker holds the following on every cycle:
- An acceptance happens only after a boundary where `gie` was set, a source was active and no NMI, skip or running sequence stood in the way.
- `gie` is low once a sequence starts.
- The push and the PC load fall at the first and seventh cycles of a sequence of exactly seven.
- A reported vector index is always active, with no active source of higher priority.
- A strobed event is always visible as pending on the next clock.

Some behaviours appear only in the bench's scenarios:
- Deferral past a skipped boundary.
- Firing of a pending flag that was set before its enable.
- Loss of a simultaneous software write to `gie` against the acceptance.
- Re-entry after software sets `gie` again.
- Pending flags surviving an NMI.
- The exact return address pushed.

The bench's reference model compares every output each cycle, so these sequences are also pinned down in time.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
   // width of an index able to address n entries (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/mirq_pending_bank.sv
module mirq_pending_bank #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_strobe,
   input  logic [NSRC-1:0] clr_mask,
   output logic [NSRC-1:0] flags
);
   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_strobe[i])
            flags[i] <= 1'b1;        // set dominates a same-cycle clear
         else if (clr_mask[i])
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/mirq_prio_pick.sv
module mirq_prio_pick #(
   parameter int NSRC = 8,
   parameter int IW   = 3
) (
   input  logic [NSRC-1:0] req,
   output logic [IW-1:0]   idx,
   output logic            valid
);
   if (NSRC == 1) begin : g_single
      assign idx   = '0;
      assign valid = req[0];
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);   // lowest index wins
         end
      end
      assign valid = |req;
   end
endmodule

// File: rtl/mirq_ack_seq.sv
module mirq_ack_seq
   import mirq_pkg::*;
#(
   parameter int          AW         = 12,
   parameter int          ACK_CYCLES = 7,
   parameter logic [AW-1:0] VECTOR   = 12'h0FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ret_addr,
   output logic          busy,
   output logic          push_valid,
   output logic [AW-1:0] push_data,
   output logic          pc_load,
   output logic [AW-1:0] pc_value
);
   localparam int CW = idx_width(ACK_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

   seq_state_e    state;
   logic [CW-1:0] step;
   logic [AW-1:0] saved_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         step       <= '0;
         saved_addr <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (start) begin
               state      <= SEQ_RUN;
               step       <= '0;
               saved_addr <= ret_addr;
            end
            SEQ_RUN: begin
               if (step == LAST) begin
                  state <= SEQ_IDLE;
                  step  <= '0;
               end else begin
                  step <= step + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state == SEQ_RUN);
   assign push_valid = busy && (step == '0);
   assign push_data  = saved_addr;
   assign pc_load    = busy && (step == LAST);
   assign pc_value   = VECTOR;
endmodule

// File: rtl/mirq_sequencer.sv
module mirq_sequencer
   import mirq_pkg::*;
#(
   parameter int            NSRC       = 8,
   parameter int            AW         = 12,
   parameter int            ACK_CYCLES = 7,
   parameter logic [AW-1:0] VECTOR     = 12'h0FF,
   parameter int            IW         = idx_width(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_strobe,
   input  logic [NSRC-1:0] pend_clr,
   input  logic            en_wr,
   input  logic [NSRC-1:0] en_wdata,
   input  logic            gie_wr,
   input  logic            gie_wdata,
   input  logic            insn_start,
   input  logic            skip_pending,
   input  logic            nmi_busy,
   input  logic [AW-1:0]   ret_addr,
   output logic            gie,
   output logic [NSRC-1:0] enable,
   output logic [NSRC-1:0] pending,
   output logic [IW-1:0]   vis_idx,
   output logic            vis_valid,
   output logic            ack_busy,
   output logic            push_valid,
   output logic [AW-1:0]   push_data,
   output logic            pc_load,
   output logic [AW-1:0]   pc_value
);
   // elaboration-time parameter checks
   if (NSRC < 1 || NSRC > 64) begin : g_bad_nsrc
      $error("mirq_sequencer: NSRC must be 1..64");
   end
   if (ACK_CYCLES < 2) begin : g_bad_ack
      $error("mirq_sequencer: ACK_CYCLES must be at least 2");
   end
   if (IW < idx_width(NSRC)) begin : g_bad_iw
      $error("mirq_sequencer: IW too narrow for NSRC");
   end

   logic [NSRC-1:0] active;
   logic            take;

   mirq_pending_bank #(.NSRC(NSRC)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_strobe (evt_strobe),
      .clr_mask   (pend_clr),
      .flags      (pending)
   );

   assign active = pending & enable;

   mirq_prio_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
      .req   (active),
      .idx   (vis_idx),
      .valid (vis_valid)
   );

   assign take = insn_start && gie && vis_valid && !nmi_busy
              && !skip_pending && !ack_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie    <= 1'b0;
         enable <= '0;
      end else begin
         if (take)        gie <= 1'b0;     // acceptance beats software write
         else if (gie_wr) gie <= gie_wdata;
         if (en_wr)       enable <= en_wdata;
      end
   end

   mirq_ack_seq #(.AW(AW), .ACK_CYCLES(ACK_CYCLES), .VECTOR(VECTOR)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (take),
      .ret_addr   (ret_addr),
      .busy       (ack_busy),
      .push_valid (push_valid),
      .push_data  (push_data),
      .pc_load    (pc_load),
      .pc_value   (pc_value)
   );
endmodule

// File: rtl/mirq_sequencer_chk.sv
module mirq_sequencer_chk #(
   parameter int            NSRC       = 8,
   parameter int            AW         = 12,
   parameter int            ACK_CYCLES = 7,
   parameter logic [AW-1:0] VECTOR     = 12'h0FF,
   parameter int            IW         = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] evt_strobe,
   input logic            insn_start,
   input logic            skip_pending,
   input logic            nmi_busy,
   input logic            gie,
   input logic [NSRC-1:0] enable,
   input logic [NSRC-1:0] pending,
   input logic [IW-1:0]   vis_idx,
   input logic            vis_valid,
   input logic            ack_busy,
   input logic            push_valid,
   input logic            pc_load,
   input logic [AW-1:0]   pc_value
);
   int unsigned     run_len;
   logic [NSRC-1:0] higher_mask;
   logic            any_active;

   always_ff @(posedge clk) begin
      if (!rst_n)        run_len <= 0;
      else if (ack_busy) run_len <= run_len + 1;
      else               run_len <= 0;
   end

   always_comb begin
      higher_mask = '0;
      for (int i = 0; i < NSRC; i++)
         if (i < int'(vis_idx)) higher_mask[i] = 1'b1;
      any_active = |(pending & enable);
   end

   assert_accept_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_busy) |-> $past(gie) && $past(insn_start) && $past(any_active)
                          && !$past(nmi_busy) && !$past(skip_pending));

   assert_no_accept_nmi_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_busy && nmi_busy) |=> !ack_busy);

   assert_gie_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_busy) |-> !gie);

   assert_push_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> ack_busy && run_len == 0);

   assert_pc_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> run_len == ACK_CYCLES - 1 && pc_value == VECTOR);

   assert_run_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_busy |-> run_len < ACK_CYCLES);

   assert_run_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !ack_busy);

   assert_vis_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vis_valid |-> pending[vis_idx] && enable[vis_idx]
                    && ((pending & enable & higher_mask) == '0));

   assert_vis_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_valid |-> !any_active);

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pending & $past(evt_strobe)) == $past(evt_strobe)));
endmodule

bind mirq_sequencer mirq_sequencer_chk #(
   .NSRC(NSRC), .AW(AW), .ACK_CYCLES(ACK_CYCLES), .VECTOR(VECTOR), .IW(IW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_strobe   (evt_strobe),
   .insn_start   (insn_start),
   .skip_pending (skip_pending),
   .nmi_busy     (nmi_busy),
   .gie          (gie),
   .enable       (enable),
   .pending      (pending),
   .vis_idx      (vis_idx),
   .vis_valid    (vis_valid),
   .ack_busy     (ack_busy),
   .push_valid   (push_valid),
   .pc_load      (pc_load),
   .pc_value     (pc_value)
);

// File: tb/sim_mirq_sequencer.sv
`timescale 1ns/1ps
module sim_mirq_sequencer;
   localparam int NSRC = 8;
   localparam int AW   = 12;
   localparam int IW   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] evt_strobe = '0, pend_clr = '0, en_wdata = '0;
   logic            en_wr = 0, gie_wr = 0, gie_wdata = 0;
   logic            insn_start = 0, skip_pending = 0, nmi_busy = 0;
   logic [AW-1:0]   ret_addr = '0;
   logic            gie, vis_valid, ack_busy, push_valid, pc_load;
   logic [NSRC-1:0] enable, pending;
   logic [IW-1:0]   vis_idx;
   logic [AW-1:0]   push_data, pc_value;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mirq_sequencer u0 (.*);

   // behavioural reference model
   bit        m_gie, m_busy;
   bit [NSRC-1:0] m_en, m_pend;
   int        m_step;
   bit [AW-1:0] m_ret;
   int        m_takes = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_gie = 0; m_en = '0; m_pend = '0; m_busy = 0; m_step = 0; m_ret = '0;
      end else begin
         bit tk;
         tk = insn_start && m_gie && ((m_pend & m_en) != 0) && !nmi_busy
              && !skip_pending && !m_busy;
         m_pend = (m_pend & ~pend_clr) | evt_strobe;
         if (en_wr) m_en = en_wdata;
         if (tk) m_gie = 0; else if (gie_wr) m_gie = gie_wdata;
         if (m_busy) begin
            if (m_step == 6) begin m_busy = 0; m_step = 0; end
            else m_step++;
         end else if (tk) begin
            m_busy = 1; m_step = 0; m_ret = ret_addr; m_takes++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int ei; bit ev;
         ev = 0; ei = 0;
         for (int i = NSRC - 1; i >= 0; i--) if (m_pend[i] & m_en[i]) begin ev = 1; ei = i; end
         chk(gie == m_gie, "R7 gie", gie, m_gie);
         chk(enable == m_en, "R3 enable", enable, m_en);
         chk(pending == m_pend, "R2 pending", pending, m_pend);
         chk(vis_valid == ev && (!ev || vis_idx == IW'(ei)), "R10 vis",
             {vis_valid, vis_idx}, {ev, IW'(ei)});
         chk(ack_busy == m_busy, "R4 ack_busy", ack_busy, m_busy);
         chk(push_valid == (m_busy && m_step == 0) && (!push_valid || push_data == m_ret),
             "R8 push", {push_valid, push_data}, {(m_busy && m_step == 0), m_ret});
         chk(pc_load == (m_busy && m_step == 6) && pc_value == 12'h0FF,
             "R9 pc", {pc_load, pc_value}, {(m_busy && m_step == 6), 12'h0FF});
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      evt_strobe = '0; pend_clr = '0; en_wr = 0; gie_wr = 0;
      insn_start = 0; skip_pending = 0;
   endtask

   task automatic sample_at_neg();
      @(negedge clk); #1;
   endtask

   task automatic boundary(input bit [AW-1:0] a);
      insn_start = 1; ret_addr = a; cyc();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      sample_at_neg();
      chk(gie == 0 && enable == 0 && pending == 0 && !ack_busy, "R1 reset",
          {gie, enable, pending, ack_busy}, 0);

      // event with everything masked: no acceptance
      evt_strobe = 8'h08; cyc();
      boundary(12'h010);
      sample_at_neg();
      chk(!ack_busy && pending == 8'h08, "R2 pend kept, no take",
          {ack_busy, pending}, 8'h08);

      // enable source 3 and gie; first boundary skipped
      en_wr = 1; en_wdata = 8'h08; gie_wr = 1; gie_wdata = 1; cyc();
      insn_start = 1; skip_pending = 1; ret_addr = 12'h020; cyc();
      sample_at_neg();
      chk(!ack_busy, "R6 skip defers", ack_busy, 0);
      boundary(12'h021);
      sample_at_neg();
      chk(ack_busy && push_valid && push_data == 12'h021, "R5 prior pending fires",
          {ack_busy, push_valid, push_data}, {1'b1, 1'b1, 12'h021});
      // boundaries and events during the run
      evt_strobe = 8'h22; cyc();
      boundary(12'h030);
      repeat (6) cyc();
      sample_at_neg();
      chk(!ack_busy && gie == 0 && pending == 8'h2A, "R9 run ended, flags kept",
          {ack_busy, gie, pending}, 8'h2A);

      // nmi blocks
      en_wr = 1; en_wdata = 8'h2A; gie_wr = 1; gie_wdata = 1; cyc();
      nmi_busy = 1; boundary(12'h040);
      sample_at_neg();
      chk(!ack_busy && pending == 8'h2A, "R12 nmi blocks", {ack_busy, pending}, 8'h2A);
      chk(vis_valid && vis_idx == 3'd1, "R10 priority index", vis_idx, 1);
      nmi_busy = 0;

      // acceptance with simultaneous gie write
      gie_wr = 1; gie_wdata = 1; boundary(12'h050);
      sample_at_neg();
      chk(ack_busy && gie == 0, "R7 gie cleared over write", {ack_busy, gie}, 2'b10);
      repeat (7) cyc();

      // nesting: set gie again, next boundary accepted
      gie_wr = 1; gie_wdata = 1; cyc();
      boundary(12'h060);
      sample_at_neg();
      chk(ack_busy && push_data == 12'h060, "R11 re-entry", push_data, 12'h060);
      repeat (7) cyc();

      // set and clear together, then clear all
      evt_strobe = 8'h80; pend_clr = 8'h82; cyc();
      sample_at_neg();
      chk(pending == 8'hA8, "R2 set wins", pending, 8'hA8);
      pend_clr = 8'hFF; cyc();
      sample_at_neg();
      chk(!vis_valid && pending == 0, "R10 none active", {vis_valid, pending}, 0);
      gie_wr = 1; gie_wdata = 1; cyc();
      boundary(12'h070);
      sample_at_neg();
      chk(!ack_busy, "R4 no active source", ack_busy, 0);
      chk(m_takes == 3, "R4 take count", m_takes, 3);

      repeat (3) cyc();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule